// File: doc/BRIEF.md
# Extended Load/Store Address Generator

This block forms the memory addresses for the extended load and store forms of a 64-bit core. For each request it returns one or two byte addresses. When the form updates its base register, it also returns the new base value and a write enable. An illegal flag rejects operand combinations that cannot be executed. Memory access, alignment handling and extension of loaded data are handled by other blocks.

Five forms are selected by a 3-bit mode code:
- **Scaled index.** The base plus an index shifted left by 0 to 3.
- **Zero-extended scaled index.** As above, but only the low 32 bits of the index are used, zero-extended.
- **Post-increment.** The access uses the current base. The base register is then advanced.
- **Pre-increment.** The base is advanced first and the access uses the new value.
- **Paired.** Two adjacent word or doubleword accesses are made at a scaled offset from the base.

Requests enter with a valid strobe and results appear on registered outputs one cycle later. A new request can be accepted on every cycle.

Top module: `lsx_agu`

## Requirements
- R1: With mode code 0, addr0 equals base + (index << shamt), where shamt is the 2-bit shift input.
- R2: With mode code 1, addr0 equals base + (zero-extended index[31:0] << shamt); the upper 32 bits of index have no effect.
- R3: With mode codes 2 and 3, the increment is the 5-bit immediate taken as a signed value, sign-extended, then shifted left by shamt. When the request is legal, wb_en is 1 and wb_value equals base + increment.
- R4: Mode code 2 (post-increment) gives addr0 = base. Mode code 3 (pre-increment) gives addr0 = base + increment.
- R5: In mode codes 2 and 3, a load (is_load = 1) whose data_reg equals base_reg sets illegal. A store with the same register numbers is legal.
- R6: With mode code 4, size code 3 selects doubleword pairs and size code 2 selects word pairs. For doubleword pairs addr0 = base + (shamt << 4) and addr1 = addr0 + 8. For word pairs addr0 = base + (shamt << 3) and addr1 = addr0 + 4. A legal pair sets addr1_valid to 1.
- R7: With mode code 4, the request is illegal when any of these holds, for loads and stores alike:
  - base_reg equals data_reg;
  - base_reg equals data_reg2;
  - data_reg equals data_reg2;
  - the size code is below 2 (size code 0 is byte, 1 is halfword).
- R8: Mode codes 5 to 7 are illegal. For any illegal request, wb_en and addr1_valid are 0.
- R9: Every output is registered. out_valid is in_valid delayed by one clock cycle. Reset clears out_valid, wb_en, addr1_valid, illegal and both addresses.
- R10: All address and writeback sums wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Form select: 0 index, 1 zero-extended index, 2 post-increment, 3 pre-increment, 4 pair |
| size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 doubleword |
| is_load | input | 1 | 1 for a load, 0 for a store |
| base | input | 64 | Base register value |
| index | input | 64 | Index register value |
| shamt | input | 2 | Scale shift, also the pair offset field |
| imm | input | 5 | Signed increment immediate |
| base_reg | input | 5 | Base register number |
| data_reg | input | 5 | First data register number |
| data_reg2 | input | 5 | Second data register number (pair) |
| out_valid | output | 1 | Result strobe |
| addr0 | output | 64 | First access address |
| addr1_valid | output | 1 | Second address present |
| addr1 | output | 64 | Second access address (pair) |
| wb_en | output | 1 | Base register writeback enable |
| wb_value | output | 64 | Updated base value |
| illegal | output | 1 | Illegal-instruction flag |

## Verification
Several properties are checked by assertions on every cycle:
- the one-cycle valid timing;
- the suppression of writeback and of the second address on illegal requests;
- the 4- or 8-byte spacing of paired addresses;
- the load/base clash flag;
- the post-increment address equal to the old base and the pre-increment address equal to the written-back base.

Other properties can only be shown by the bench's scenarios:
- the exact scaled-index sums;
- the discarding of the upper index half in the zero-extended form;
- sign extension of negative immediates;
- each overlap condition for pairs;
- reserved modes;
- wraparound at the top of the address space;
- back-to-back requests followed by idle gaps.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
  typedef enum logic [2:0] {
    MODE_IDX      = 3'd0,
    MODE_IDX_ZX   = 3'd1,
    MODE_INC_POST = 3'd2,
    MODE_INC_PRE  = 3'd3,
    MODE_PAIR     = 3'd4
  } lsx_mode_e;

  localparam logic [1:0] SIZE_WORD  = 2'd2;
  localparam logic [1:0] SIZE_DWORD = 2'd3;
endpackage

// File: rtl/lsx_idx_path.sv
module lsx_idx_path #(
  parameter int XLEN = 64,
  parameter int ZX_W = 32,
  parameter int SH_W = 2
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] index,
  input  logic [SH_W-1:0] shamt,
  input  logic            zero_ext,
  output logic [XLEN-1:0] addr
);
  localparam int PAD_W = XLEN - ZX_W;

  function automatic logic [XLEN-1:0] scale_index(
    input logic [XLEN-1:0] idx, input logic [SH_W-1:0] sh, input logic zx);
    logic [XLEN-1:0] v;
    v = zx ? {{PAD_W{1'b0}}, idx[ZX_W-1:0]} : idx;
    return v << sh;
  endfunction

  assign addr = base + scale_index(index, shamt, zero_ext);
endmodule

// File: rtl/lsx_inc_path.sv
module lsx_inc_path #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 5,
  parameter int SH_W  = 2
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  input  logic [SH_W-1:0]  shamt,
  input  logic             pre,
  output logic [XLEN-1:0]  addr,
  output logic [XLEN-1:0]  next_base
);
  localparam int EXT_W = XLEN - IMM_W;

  function automatic logic [XLEN-1:0] step_amount(
    input logic [IMM_W-1:0] im, input logic [SH_W-1:0] sh);
    logic [XLEN-1:0] ext;
    ext = {{EXT_W{im[IMM_W-1]}}, im};
    return ext << sh;
  endfunction

  assign next_base = base + step_amount(imm, shamt);
  assign addr      = pre ? next_base : base;
endmodule

// File: rtl/lsx_pair_path.sv
module lsx_pair_path #(
  parameter int XLEN = 64,
  parameter int SH_W = 2
) (
  input  logic [XLEN-1:0] base,
  input  logic [SH_W-1:0] shamt,
  input  logic            dword,
  output logic [XLEN-1:0] addr_lo,
  output logic [XLEN-1:0] addr_hi
);
  localparam int DW_SHIFT = 4;
  localparam int W_SHIFT  = 3;
  localparam logic [XLEN-1:0] DW_BYTES = XLEN'(8);
  localparam logic [XLEN-1:0] W_BYTES  = XLEN'(4);

  function automatic logic [XLEN-1:0] pair_offset(
    input logic [SH_W-1:0] sh, input logic dw);
    logic [XLEN-1:0] z;
    z = XLEN'(sh);
    return dw ? (z << DW_SHIFT) : (z << W_SHIFT);
  endfunction

  assign addr_lo = base + pair_offset(shamt, dword);
  assign addr_hi = addr_lo + (dword ? DW_BYTES : W_BYTES);
endmodule

// File: rtl/lsx_agu.sv
module lsx_agu #(
  parameter int XLEN  = 64,
  parameter int REG_W = 5,
  parameter int IMM_W = 5,
  parameter int SH_W  = 2,
  parameter int ZX_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       mode,
  input  logic [1:0]       size,
  input  logic             is_load,
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN-1:0]  index,
  input  logic [SH_W-1:0]  shamt,
  input  logic [IMM_W-1:0] imm,
  input  logic [REG_W-1:0] base_reg,
  input  logic [REG_W-1:0] data_reg,
  input  logic [REG_W-1:0] data_reg2,
  output logic             out_valid,
  output logic [XLEN-1:0]  addr0,
  output logic             addr1_valid,
  output logic [XLEN-1:0]  addr1,
  output logic             wb_en,
  output logic [XLEN-1:0]  wb_value,
  output logic             illegal
);
  import lsx_pkg::*;

  lsx_mode_e mode_e;
  assign mode_e = lsx_mode_e'(mode);

  // Decoded form flags, brought out for the assertions
  logic is_idx, is_inc, is_pre, is_pair, is_reserved;
  always_comb begin
    is_idx = 1'b0; is_inc = 1'b0; is_pre = 1'b0; is_pair = 1'b0; is_reserved = 1'b0;
    case (mode_e)
      MODE_IDX, MODE_IDX_ZX: is_idx = 1'b1;
      MODE_INC_POST:         is_inc = 1'b1;
      MODE_INC_PRE: begin
        is_inc = 1'b1;
        is_pre = 1'b1;
      end
      MODE_PAIR:             is_pair = 1'b1;
      default:               is_reserved = 1'b1;
    endcase
  end

  // Datapaths
  logic [XLEN-1:0] idx_addr, inc_addr, inc_next, pair_lo, pair_hi;

  lsx_idx_path #(.XLEN(XLEN), .ZX_W(ZX_W), .SH_W(SH_W)) u_idx (
    .base(base), .index(index), .shamt(shamt),
    .zero_ext(mode_e == MODE_IDX_ZX), .addr(idx_addr));

  lsx_inc_path #(.XLEN(XLEN), .IMM_W(IMM_W), .SH_W(SH_W)) u_inc (
    .base(base), .imm(imm), .shamt(shamt), .pre(is_pre),
    .addr(inc_addr), .next_base(inc_next));

  lsx_pair_path #(.XLEN(XLEN), .SH_W(SH_W)) u_pair (
    .base(base), .shamt(shamt), .dword(size == SIZE_DWORD),
    .addr_lo(pair_lo), .addr_hi(pair_hi));

  // Legality events
  logic inc_clash, pair_clash, ill_c;
  assign inc_clash  = is_inc && is_load && (data_reg == base_reg);
  assign pair_clash = is_pair && ((base_reg == data_reg) || (base_reg == data_reg2) ||
                                  (data_reg == data_reg2) || (size < SIZE_WORD));
  assign ill_c      = is_reserved || inc_clash || pair_clash;

  logic [XLEN-1:0] addr0_c;
  always_comb begin
    if (is_idx)       addr0_c = idx_addr;
    else if (is_inc)  addr0_c = inc_addr;
    else if (is_pair) addr0_c = pair_lo;
    else              addr0_c = '0;
  end

  logic wb_en_c, a1v_c;
  assign wb_en_c = is_inc && !ill_c;
  assign a1v_c   = is_pair && !ill_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      addr0       <= '0;
      addr1_valid <= 1'b0;
      addr1       <= '0;
      wb_en       <= 1'b0;
      wb_value    <= '0;
      illegal     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        addr0       <= addr0_c;
        addr1_valid <= a1v_c;
        addr1       <= a1v_c ? pair_hi : '0;
        wb_en       <= wb_en_c;
        wb_value    <= wb_en_c ? inc_next : '0;
        illegal     <= ill_c;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (!wb_en && !addr1_valid)); // R8
  AST_LOAD_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_inc && is_load && data_reg == base_reg) |=> illegal); // R5
  AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_e == MODE_INC_POST) |=> (addr0 == $past(base))); // R4
  AST_PRE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_pre && !inc_clash) |=> (addr0 == wb_value)); // R4
  AST_PAIR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && addr1_valid) |->
      ((addr1 - addr0 == XLEN'(4)) || (addr1 - addr0 == XLEN'(8)))); // R6
endmodule

// File: tb/lsx_agu_tb.sv
module lsx_agu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  size = '0;
  logic        is_load = 1'b0;
  logic [63:0] base = '0, index = '0;
  logic [1:0]  shamt = '0;
  logic [4:0]  imm = '0;
  logic [4:0]  base_reg = '0, data_reg = '0, data_reg2 = '0;
  logic        out_valid, addr1_valid, wb_en, illegal;
  logic [63:0] addr0, addr1, wb_value;

  always #4 clk = ~clk;

  lsx_agu u_dut (.*);

  typedef struct {
    string       tag;
    logic        ill;
    logic        wbe;
    logic [63:0] wbv;
    logic [63:0] a0;
    logic        a1v;
    logic [63:0] a1;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected values from the requirements, written with multiplication
  task automatic drv(string tag, logic [2:0] m, logic [1:0] sz, logic ld,
                     logic [63:0] b, logic [63:0] ix, logic [1:0] sh, logic [4:0] im,
                     logic [4:0] rb, logic [4:0] rd, logic [4:0] rd2);
    exp_t e;
    logic [63:0] scale, incv, off;
    @(negedge clk);
    in_valid = 1'b1; mode = m; size = sz; is_load = ld; base = b; index = ix;
    shamt = sh; imm = im; base_reg = rb; data_reg = rd; data_reg2 = rd2;
    scale = 64'd1 << sh;
    e.tag = tag; e.ill = 0; e.wbe = 0; e.wbv = 0; e.a0 = 0; e.a1v = 0; e.a1 = 0;
    case (m)
      3'd0: e.a0 = b + ix * scale;
      3'd1: e.a0 = b + {32'd0, ix[31:0]} * scale;
      3'd2, 3'd3: begin
        incv = {{59{im[4]}}, im} * scale;
        e.ill = ld && (rd == rb);
        e.wbe = !e.ill;
        e.wbv = b + incv;
        e.a0  = (m == 3'd3) ? b + incv : b;
      end
      3'd4: begin
        e.ill = (rb == rd) || (rb == rd2) || (rd == rd2) || (sz < 2);
        off   = (sz == 2'd3) ? 64'(sh) * 16 : 64'(sh) * 8;
        e.a0  = b + off;
        e.a1v = !e.ill;
        e.a1  = e.a0 + ((sz == 2'd3) ? 64'd8 : 64'd4);
      end
      default: e.ill = 1;
    endcase
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares each result against the oldest expected item
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 spurious out_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " illegal"}, 64'(illegal), 64'(e.ill));
        chk({e.tag, " wb_en"}, 64'(wb_en), 64'(e.wbe));
        chk({e.tag, " addr1_valid"}, 64'(addr1_valid), 64'(e.a1v));
        if (!e.ill) chk({e.tag, " addr0"}, addr0, e.a0);
        if (e.wbe)  chk({e.tag, " wb_value"}, wb_value, e.wbv);
        if (e.a1v)  chk({e.tag, " addr1"}, addr1, e.a1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset out_valid", 64'(out_valid), 64'd0);
    chk("R9 reset wb_en", 64'(wb_en), 64'd0);
    chk("R9 reset illegal", 64'(illegal), 64'd0);
    chk("R9 reset addr0", addr0, 64'd0);

    drv("R1 index", 3'd0, 2'd3, 1, 64'h1000, 64'h10, 2'd3, 5'd0, 5'd1, 5'd2, 5'd0);
    drv("R1 R10 negative index", 3'd0, 2'd2, 1, 64'h2000, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 5'd0, 5'd1, 5'd2, 5'd0);
    drv("R2 upper half dropped", 3'd1, 2'd2, 0, 64'h4000, 64'hFFFF_FFFF_0000_0010, 2'd1, 5'd0, 5'd1, 5'd2, 5'd0);
    drv("R2 bit31 unsigned", 3'd1, 2'd3, 1, 64'h10, 64'h0000_0000_8000_0000, 2'd3, 5'd0, 5'd3, 5'd4, 5'd0);
    idle(2);
    drv("R3 R4 post negative imm", 3'd2, 2'd3, 1, 64'h1_0000, 64'h0, 2'd3, 5'b10000, 5'd5, 5'd6, 5'd0);
    drv("R3 R4 pre positive imm", 3'd3, 2'd2, 0, 64'h500, 64'h0, 2'd0, 5'd15, 5'd7, 5'd7, 5'd0);
    drv("R5 load clash", 3'd2, 2'd2, 1, 64'h800, 64'h0, 2'd1, 5'd4, 5'd9, 5'd9, 5'd0);
    drv("R5 R8 pre load clash", 3'd3, 2'd0, 1, 64'h800, 64'h0, 2'd1, 5'd4, 5'd3, 5'd3, 5'd0);
    drv("R3 R4 pre imm -1", 3'd3, 2'd0, 1, 64'h800, 64'h0, 2'd2, 5'b11111, 5'd3, 5'd8, 5'd0);
    drv("R6 pair dword", 3'd4, 2'd3, 1, 64'h3000, 64'h0, 2'd3, 5'd0, 5'd1, 5'd2, 5'd3);
    drv("R6 pair word", 3'd4, 2'd2, 0, 64'h3000, 64'h0, 2'd1, 5'd0, 5'd1, 5'd2, 5'd3);
    idle(1);
    drv("R7 pair base=rd", 3'd4, 2'd3, 1, 64'h3000, 64'h0, 2'd0, 5'd0, 5'd4, 5'd4, 5'd5);
    drv("R7 pair base=rd2", 3'd4, 2'd3, 0, 64'h3000, 64'h0, 2'd0, 5'd0, 5'd4, 5'd6, 5'd4);
    drv("R7 pair rd=rd2", 3'd4, 2'd2, 1, 64'h3000, 64'h0, 2'd0, 5'd0, 5'd4, 5'd7, 5'd7);
    drv("R7 pair byte size", 3'd4, 2'd0, 1, 64'h3000, 64'h0, 2'd0, 5'd0, 5'd4, 5'd7, 5'd8);
    drv("R8 reserved mode 5", 3'd5, 2'd3, 1, 64'h3000, 64'h0, 2'd0, 5'd1, 5'd4, 5'd7, 5'd8);
    drv("R8 reserved mode 7", 3'd7, 2'd3, 0, 64'h3000, 64'h0, 2'd0, 5'd1, 5'd4, 5'd7, 5'd8);
    drv("R10 index wrap", 3'd0, 2'd3, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 2'd0, 5'd0, 5'd1, 5'd2, 5'd0);
    drv("R10 pair wrap", 3'd4, 2'd3, 1, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 2'd0, 5'd0, 5'd1, 5'd2, 5'd3);
    drv("R10 increment wrap", 3'd2, 2'd3, 0, 64'h0, 64'h0, 2'd0, 5'b11000, 5'd1, 5'd2, 5'd0);
    idle(4);
    chk("R9 idle out_valid", 64'(out_valid), 64'd0);
    chk("R9 all results seen", 64'(q.size()), 64'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule